// File: doc/BRIEF.md
# Four-Lane Masked Vector Add/Subtract Unit

This block performs an element-wise integer add or subtract over two vector operands of up to sixteen 32-bit elements. Elements are spread across four parallel lanes in interleaved order: lane k handles elements k, k+4, k+8 and k+12. Only elements below the requested vector length take part. A per-element mask decides which results are committed to the destination vector. Destination elements that are not written keep the value they already held, from reset or from an earlier operation.

Two execution modes are offered. In the simple mode the unit walks the vector one element group of four per cycle, computes every element, and uses the mask only as a write enable, so the run time depends on the vector length alone. In the density-time mode the unit gathers the active elements (mask bit set and index below the length) and issues up to four of them per cycle, lowest index first. Inactive elements never reach an adder, so the run time depends on the number of active elements. An operation begins with a start strobe and ends with a one-cycle done pulse. The number of processing cycles is kept on an output so that it can be checked.

Top module: `vec_mask_alu`

## Requirements
- R1: Each written element i is `opA[i] + opB[i]` when `opSub` is 0 and `opA[i] - opB[i]` when `opSub` is 1, modulo 2^32. Element i occupies bits [32i+31:32i] of `vecA`, `vecB` and `result`.
- R2: In simple mode (`denseMode` = 0) one group of four consecutive elements is handled per cycle, so `cycleCount` ends at ceil(`vlen`/4), whatever the mask.
- R3: Element i is written, and `wrEn[i]` is set, only when `mask[i]` (bit i for element i) is 1. `wrEn` is cleared when an operation is accepted. It then shows which elements that operation wrote.
- R4: Elements with index at or beyond `vlen` (range 0 to 16) are never written, whatever their mask bit.
- R5: Destination elements that are not written keep their previous value, and `result` does not change while the unit is idle.
- R6: In density-time mode (`denseMode` = 1) `cycleCount` ends at ceil(P/4), where P counts elements with mask bit 1 and index below `vlen`.
- R7: `busy` rises on the edge that accepts `start`. `done` is a single-cycle pulse issued max(C,1) cycles after that edge, where C is the final `cycleCount`. `busy` falls on the same edge as `done` rises.
- R8: A `start` asserted while `busy` is high is ignored. The running operation and its operands are unaffected.
- R9: After reset, `result`, `wrEn`, `cycleCount`, `busy` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| denseMode | input | 1 | 0 = simple mode, 1 = density-time mode |
| opSub | input | 1 | 0 = add, 1 = subtract |
| vecA | input | 512 | First operand vector, element i at [32i+31:32i] |
| vecB | input | 512 | Second operand vector |
| mask | input | 16 | Per-element write mask, bit i for element i |
| vlen | input | 5 | Vector length, 0 to 16 |
| result | output | 512 | Destination vector |
| wrEn | output | 16 | Elements written by the latest operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycleCount | output | 5 | Processing cycles used by the latest operation |

## Verification
The assertions assume that `vlen` never exceeds 16 and that reset is held low from time zero until the first clock edges have passed. Under those assumptions the idle-hold, done-pulse and cycle-bound properties stay meaningful. The stimulus draws `vlen` only from 0 to 16 and holds reset from the start. It samples `start`, operands, mask and mode only at the accepting edge. To test that a start during a run has no effect, the bench raises `start` with altered operands during a run and then confirms that the committed result is still the one computed from the original operands.

// File: rtl/va_pkg.sv
package va_pkg;
  localparam int VA_LANES  = 4;
  localparam int VA_MAX_VL = 16;
  localparam int VA_ELEM_W = 32;
  localparam int VA_IDX_W  = $clog2(VA_MAX_VL);
  localparam int VA_LEN_W  = $clog2(VA_MAX_VL + 1);

  typedef struct packed {
    logic                                load;
    logic                                step;
    logic [VA_LANES-1:0]                 laneVld;
    logic [VA_LANES-1:0][VA_IDX_W-1:0]   laneIdx;
  } va_strobe_t;
endpackage

// File: rtl/va_ctrl.sv
module va_ctrl import va_pkg::*; #(
  parameter int LANES  = VA_LANES,
  parameter int MAX_VL = VA_MAX_VL,
  parameter int IDX_W  = VA_IDX_W,
  parameter int LEN_W  = VA_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              modeIn,
  input  logic [MAX_VL-1:0] maskIn,
  input  logic [LEN_W-1:0]  vlenIn,
  output va_strobe_t        strobe,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-1:0]  cycleCount
);
  localparam int GROUPS = MAX_VL / LANES;
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_t;

  ctrl_state_t       state;
  logic              modeR;
  logic [LEN_W-1:0]  lenR;
  logic [MAX_VL-1:0] pend;
  logic [GRP_W-1:0]  grp;
  logic [LEN_W-1:0]  cnt;
  logic              doneR;

  logic [MAX_VL-1:0]             lenMask;
  logic [MAX_VL-1:0]             take;
  logic [LANES-1:0]              laneVld;
  logic [LANES-1:0][IDX_W-1:0]   laneIdx;
  logic [SEL_W:0]                nSel;
  logic                          noWork;
  logic                          lastStep;

  always_comb begin
    for (int i = 0; i < MAX_VL; i++) begin
      lenMask[i] = (LEN_W'(i) < vlenIn);
    end
  end

  // lane selection: fixed groups in simple mode, packed actives in dense mode
  always_comb begin
    laneVld = '0;
    laneIdx = '0;
    take    = '0;
    nSel    = '0;
    if (!modeR) begin
      for (int k = 0; k < LANES; k++) begin
        laneIdx[k] = IDX_W'(int'(grp) * LANES + k);
        laneVld[k] = pend[IDX_W'(int'(grp) * LANES + k)];
      end
    end else begin
      for (int i = 0; i < MAX_VL; i++) begin
        if (pend[i] && (int'(nSel) < LANES)) begin
          laneIdx[nSel[SEL_W-1:0]] = IDX_W'(i);
          laneVld[nSel[SEL_W-1:0]] = 1'b1;
          take[i] = 1'b1;
          nSel = nSel + 1'b1;
        end
      end
    end
  end

  assign noWork   = modeR ? (pend == '0) : (lenR == '0);
  assign lastStep = modeR ? ((pend & ~take) == '0)
                          : ((int'(grp) + 1) * LANES >= int'(lenR));

  assign strobe.load    = (state == ST_IDLE) && start;
  assign strobe.step    = (state == ST_RUN) && !noWork;
  assign strobe.laneVld = laneVld;
  assign strobe.laneIdx = laneIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      modeR <= 1'b0;
      lenR  <= '0;
      pend  <= '0;
      grp   <= '0;
      cnt   <= '0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            modeR <= modeIn;
            lenR  <= vlenIn;
            pend  <= maskIn & lenMask;
            grp   <= '0;
            cnt   <= '0;
            state <= ST_RUN;
          end
        end
        default: begin
          if (noWork) begin
            doneR <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            grp <= grp + 1'b1;
            if (modeR) pend <= pend & ~take;
            if (lastStep) begin
              doneR <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign busy       = (state == ST_RUN);
  assign done       = doneR;
  assign cycleCount = cnt;
endmodule

// File: rtl/va_dpath.sv
module va_dpath import va_pkg::*; #(
  parameter int LANES  = VA_LANES,
  parameter int MAX_VL = VA_MAX_VL,
  parameter int ELEM_W = VA_ELEM_W,
  parameter int IDX_W  = VA_IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  va_strobe_t               strobe,
  input  logic                     subIn,
  input  logic [MAX_VL*ELEM_W-1:0] vecAIn,
  input  logic [MAX_VL*ELEM_W-1:0] vecBIn,
  output logic [MAX_VL*ELEM_W-1:0] result,
  output logic [MAX_VL-1:0]        wrEn
);
  logic [ELEM_W-1:0] opA    [MAX_VL];
  logic [ELEM_W-1:0] opB    [MAX_VL];
  logic [ELEM_W-1:0] resArr [MAX_VL];
  logic [ELEM_W-1:0] laneSum[LANES];
  logic [MAX_VL-1:0] wrEnR;
  logic              subR;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ELEM_W-1:0] aSel;
    logic [ELEM_W-1:0] bSel;
    assign aSel       = opA[strobe.laneIdx[k]];
    assign bSel       = opB[strobe.laneIdx[k]];
    assign laneSum[k] = subR ? (aSel - bSel) : (aSel + bSel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_VL; i++) begin
        opA[i]    <= '0;
        opB[i]    <= '0;
        resArr[i] <= '0;
      end
      wrEnR <= '0;
      subR  <= 1'b0;
    end else if (strobe.load) begin
      for (int i = 0; i < MAX_VL; i++) begin
        opA[i] <= vecAIn[i*ELEM_W +: ELEM_W];
        opB[i] <= vecBIn[i*ELEM_W +: ELEM_W];
      end
      subR  <= subIn;
      wrEnR <= '0;
    end else if (strobe.step) begin
      for (int k = 0; k < LANES; k++) begin
        if (strobe.laneVld[k]) begin
          resArr[strobe.laneIdx[k]] <= laneSum[k];
          wrEnR[strobe.laneIdx[k]]  <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < MAX_VL; i++) begin : g_pack
    assign result[i*ELEM_W +: ELEM_W] = resArr[i];
  end
  assign wrEn = wrEnR;
endmodule

// File: rtl/vec_mask_alu.sv
module vec_mask_alu import va_pkg::*; #(
  parameter int LANES  = VA_LANES,
  parameter int MAX_VL = VA_MAX_VL,
  parameter int ELEM_W = VA_ELEM_W,
  parameter int IDX_W  = VA_IDX_W,
  parameter int LEN_W  = VA_LEN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     denseMode,
  input  logic                     opSub,
  input  logic [MAX_VL*ELEM_W-1:0] vecA,
  input  logic [MAX_VL*ELEM_W-1:0] vecB,
  input  logic [MAX_VL-1:0]        mask,
  input  logic [LEN_W-1:0]         vlen,
  output logic [MAX_VL*ELEM_W-1:0] result,
  output logic [MAX_VL-1:0]        wrEn,
  output logic                     busy,
  output logic                     done,
  output logic [LEN_W-1:0]         cycleCount
);
  va_strobe_t strobe;

  va_ctrl #(.LANES(LANES), .MAX_VL(MAX_VL), .IDX_W(IDX_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .modeIn(denseMode),
    .maskIn(mask), .vlenIn(vlen), .strobe(strobe), .busy(busy),
    .done(done), .cycleCount(cycleCount)
  );

  va_dpath #(.LANES(LANES), .MAX_VL(MAX_VL), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .subIn(opSub),
    .vecAIn(vecA), .vecBIn(vecB), .result(result), .wrEn(wrEn)
  );
endmodule

// File: rtl/va_checker.sv
module va_checker #(
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  parameter int ELEM_W = 32,
  parameter int LEN_W  = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [MAX_VL*ELEM_W-1:0] result,
  input logic [MAX_VL-1:0]        wrEn,
  input logic                     busy,
  input logic                     done,
  input logic [LEN_W-1:0]         cycleCount
);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r8_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r5_idle_holds_result: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  a_r3_writes_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrEn & ~$past(wrEn)) != '0) |-> $past(busy));

  a_r6_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(cycleCount) <= (MAX_VL + LANES - 1) / LANES));
endmodule

bind vec_mask_alu va_checker #(
  .LANES(LANES), .MAX_VL(MAX_VL), .ELEM_W(ELEM_W), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .result(result), .wrEn(wrEn),
  .busy(busy), .done(done), .cycleCount(cycleCount)
);

// File: tb/vec_mask_alu_tb_top.sv
module vec_mask_alu_tb_top;
  import va_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int VW = VA_MAX_VL * VA_ELEM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic denseMode = 1'b0;
  logic opSub = 1'b0;
  logic [VW-1:0] vecA = '0;
  logic [VW-1:0] vecB = '0;
  logic [VA_MAX_VL-1:0] mask = '0;
  logic [VA_LEN_W-1:0] vlen = '0;
  logic [VW-1:0] result;
  logic [VA_MAX_VL-1:0] wrEn;
  logic busy;
  logic done;
  logic [VA_LEN_W-1:0] cycleCount;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [VW-1:0] expRes = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_mask_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .denseMode(denseMode), .opSub(opSub),
    .vecA(vecA), .vecB(vecB), .mask(mask), .vlen(vlen), .result(result),
    .wrEn(wrEn), .busy(busy), .done(done), .cycleCount(cycleCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ceil4(input int n);
    return (n + VA_LANES - 1) / VA_LANES;
  endfunction

  task automatic runOp(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [VA_MAX_VL-1:0] m, input int vl,
                       input bit md, input bit sb, input bit inject);
    logic [VA_MAX_VL-1:0] expWr = '0;
    int active = 0;
    int expCyc;
    int waitCyc = 0;
    for (int i = 0; i < VA_MAX_VL; i++) begin
      if (m[i] && i < vl) begin
        expWr[i] = 1'b1;
        active++;
        expRes[i*VA_ELEM_W +: VA_ELEM_W] = sb ? (a[i*VA_ELEM_W +: VA_ELEM_W] - b[i*VA_ELEM_W +: VA_ELEM_W])
                                              : (a[i*VA_ELEM_W +: VA_ELEM_W] + b[i*VA_ELEM_W +: VA_ELEM_W]);
      end
    end
    expCyc = md ? ceil4(active) : ceil4(vl);
    @(negedge clk);
    vecA = a; vecB = b; mask = m; vlen = VA_LEN_W'(vl);
    denseMode = md; opSub = sb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", VW'(busy), VW'(1));
    if (inject) begin
      // R8: start with altered data during the run must be ignored
      vecA = ~a; vecB = a; mask = '1; vlen = VA_LEN_W'(VA_MAX_VL);
      denseMode = ~md; opSub = ~sb; start = 1'b1;
    end
    while (!done && waitCyc < 40) begin
      @(negedge clk);
      start = 1'b0;
      waitCyc++;
    end
    check(waitCyc == ((expCyc > 1) ? expCyc : 1), "R7", "cycles to done",
          VW'(waitCyc), VW'((expCyc > 1) ? expCyc : 1));
    check(busy == 1'b0, "R7", "busy low with done", VW'(busy), '0);
    check(int'(cycleCount) == expCyc, md ? "R6" : "R2", "cycleCount",
          VW'(cycleCount), VW'(expCyc));
    check(wrEn == expWr, "R3/R4", "wrEn", VW'(wrEn), VW'(expWr));
    check(result == expRes, "R1/R5", "result", result, expRes);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7", "done single pulse", VW'(done), '0);
    if (inject) begin
      @(negedge clk);
      check(busy == 1'b0 && result == expRes, "R8", "no run from ignored start",
            result, expRes);
    end
  endtask

  function automatic logic [VW-1:0] randVec();
    logic [VW-1:0] v;
    for (int i = 0; i < VA_MAX_VL; i++) v[i*VA_ELEM_W +: VA_ELEM_W] = $urandom;
    return v;
  endfunction

  initial begin
    logic [VW-1:0] ra;
    logic [VW-1:0] rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(result == '0, "R9", "result reset", result, '0);
    check(wrEn == '0 && busy == 1'b0 && done == 1'b0 && cycleCount == '0,
          "R9", "control reset", VW'({wrEn, busy, done, cycleCount}), '0);

    // directed corners
    ra = randVec(); rb = randVec();
    runOp(ra, rb, 16'hFFFF, 16, 1'b0, 1'b0, 1'b0);   // R2 full simple add
    runOp(rb, ra, 16'hFFFF, 16, 1'b1, 1'b1, 1'b0);   // R6 full dense sub
    runOp(randVec(), randVec(), 16'hFFFF, 0, 1'b0, 1'b0, 1'b0); // R4 zero length
    runOp(randVec(), randVec(), 16'h0000, 16, 1'b1, 1'b0, 1'b0); // R6 no actives
    runOp(randVec(), randVec(), 16'h0000, 13, 1'b0, 1'b1, 1'b0); // R2 mask ignored for time
    runOp(randVec(), randVec(), 16'hA5A5, 5, 1'b0, 1'b0, 1'b0);  // R4 partial group
    runOp(randVec(), randVec(), 16'h8001, 16, 1'b1, 1'b0, 1'b0); // R6 sparse dense
    runOp(randVec(), randVec(), 16'hFFFF, 9, 1'b1, 1'b1, 1'b1);  // R8 inject
    runOp(randVec(), randVec(), 16'h00F0, 3, 1'b1, 1'b0, 1'b1);  // R8 with no work

    for (int n = 0; n < 40; n++) begin
      runOp(randVec(), randVec(), 16'($urandom), int'($urandom_range(0, 16)),
            1'($urandom), 1'($urandom), (n % 5) == 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule